// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block is a 24-bit down-counter that produces a periodic tick for an operating-system scheduler or any other software time base. Software loads a reload value, clears the count, picks a count source and turns the counter on. On every count step the counter moves down by one. When it reaches zero it latches a sticky flag and, if allowed, pulses an interrupt request. On the next step it reloads and starts again. A reload value of N-1 therefore gives a period of N count steps, so no period above 2^24 steps can be programmed.

The count source is either the processor clock or an external reference tick. The reference tick is brought into the clock domain through a two-flop synchroniser and counts once per rising edge. A read-only calibration word reports, through parameters, the reload value for a 10 ms period and two quality flags. Four 32-bit word registers sit behind a plain register port with address, write strobe, write data, read strobe and read data. Reads are combinational in the strobe cycle.

Top module: `tick_timer`

## Requirements
- R1: After reset, the word at byte offset 0x0 reads 0x00000004, offsets 0x4 and 0x8 read 0, and offset 0xC reads the parameterised calibration word. Decode uses address bits 3:2 only.
- R2: In the control word at offset 0x0, bit 0 enables counting, bit 1 allows the interrupt, bit 2 selects the source (1 = processor clock, 0 = reference tick), and bit 16 is the zero flag. Every other bit reads 0, and writes to the other bits have no effect.
- R3: The reload word (0x4) and the count word (0x8) hold 24 bits in 23:0. Bits 31:24 read 0, and writes to them are discarded.
- R4: With the processor clock selected and bit 0 set, the count changes once per clock. With bit 0 clear, the count holds its value.
- R5: A count step taken at zero loads the reload value. A reload value of N-1 gives exactly N count steps between interrupt pulses.
- R6: The zero flag sets when a step takes the count from 1 to 0. A read of offset 0x0 returns the flag and then clears it. A set in the same cycle as the clearing read wins.
- R7: irq_o is high for exactly one cycle, the cycle after each 1-to-0 step, and only when bit 1 was set. With bit 1 clear, the flag still sets but irq_o stays low.
- R8: Any write to offset 0x8 sets the count to 0 and clears the zero flag, whatever the data. It overrides a step in the same cycle.
- R9: With the reference source selected, ref_tick_i passes through two synchronising flops. Each rising edge gives one count step, however long the input stays high.
- R10: With a reload value of 0, the count stays at 0 and no further interrupt is raised.
- R11: A step taken while the count is 0 loads the reload value and counts as no wrap: no flag and no interrupt.
- R12: The calibration word (0xC) is read-only: bits 23:0 hold the 10 ms reload value, bit 30 the inexact flag and bit 31 the no-reference flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| ref_tick_i | input | 1 | External reference tick, asynchronous to clk |
| bus_addr | input | 4 | Byte address of the register word |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe; a read of offset 0x0 clears the zero flag |
| bus_rd_data | output | 32 | Read data, valid while bus_rd_en is high, zero otherwise |
| irq_o | output | 1 | One-cycle interrupt request on each wrap |

## Verification
The hardest case to reach from the ports is the reference-tick path. There the count moves only on synchronised rising edges, two flops and an edge detector away from the pin. The bench drives long and short high phases on ref_tick_i and counts interrupt pulses, so that a level held across many clocks can be seen to give one step. A second hard case is the first step after enabling from a zero count, which must load and not wrap. The bench enables the counter directly after a clearing write and reads the count in the cycle of that first step. A behavioural model follows every cycle, so flag and read-clear collisions are compared wherever the running schedule makes them occur.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_CALIB  = 2'd3
  } reg_sel_e;

  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_IE    = 1;
  localparam int unsigned BIT_SRC   = 2;
  localparam int unsigned BIT_FLAG  = 16;
  localparam int unsigned BIT_SKEW  = 30;
  localparam int unsigned BIT_NOREF = 31;

  typedef struct packed {
    logic src;
    logic ie;
    logic en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{src: 1'b1, ie: 1'b0, en: 1'b0};
endpackage

// File: rtl/tick_src.sv
module tick_src #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  input  logic en_i,
  input  logic src_clk_i,
  output logic step_o
);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q, sync_d;
  logic         last_q, last_d;
  logic         rise_w;

  // next state: shift chain plus edge-history flop
  always_comb begin
    sync_d = {sync_q[TOP-1:0], ref_i};
    last_d = sync_q[TOP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise_w = sync_q[TOP] & ~last_q;
  assign step_o = en_i & (src_clk_i | rise_w);
endmodule

// File: rtl/tick_core.sv
module tick_core #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             ie_i,
  input  logic             clr_i,
  input  logic             rd_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             irq_q, irq_d;
  logic             wrap_w;

  assign wrap_w = step_i & (cnt_q == ONE) & ~clr_i;

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    irq_d  = wrap_w & ie_i;
    if (clr_i) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else begin
      if (step_i) begin
        if (cnt_q == '0) cnt_d = reload_i;
        else             cnt_d = cnt_q - ONE;
      end
      if (rd_clr_i) flag_d = 1'b0;
      if (wrap_w)   flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 4,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       CNT_W     = 24,
  parameter logic [CNT_W-1:0]  CAL_TENMS = '0,
  parameter bit                CAL_SKEW  = 1'b0,
  parameter bit                CAL_NOREF = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              flag_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              count_clr_o,
  output logic              flag_rd_o
);
  reg_sel_e         sel_w;
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             unused_bits;

  assign sel_w       = reg_sel_e'(bus_addr[SEL_LSB +: SEL_W]);
  assign unused_bits = ^{bus_addr, wr_data};

  always_comb begin
    ctrl_d   = ctrl_q;
    reload_d = reload_q;
    if (wr_en && sel_w == SEL_CTRL) begin
      ctrl_d.en  = wr_data[BIT_EN];
      ctrl_d.ie  = wr_data[BIT_IE];
      ctrl_d.src = wr_data[BIT_SRC];
    end
    if (wr_en && sel_w == SEL_RELOAD) reload_d = wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      reload_q <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
    end
  end

  assign count_clr_o = wr_en & (sel_w == SEL_COUNT);
  assign flag_rd_o   = rd_en & (sel_w == SEL_CTRL);

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (sel_w)
        SEL_CTRL: begin
          rd_data[BIT_EN]   = ctrl_q.en;
          rd_data[BIT_IE]   = ctrl_q.ie;
          rd_data[BIT_SRC]  = ctrl_q.src;
          rd_data[BIT_FLAG] = flag_i;
        end
        SEL_RELOAD: rd_data[CNT_W-1:0] = reload_q;
        SEL_COUNT:  rd_data[CNT_W-1:0] = cnt_i;
        SEL_CALIB: begin
          rd_data[CNT_W-1:0] = CAL_TENMS;
          rd_data[BIT_SKEW]  = CAL_SKEW;
          rd_data[BIT_NOREF] = CAL_NOREF;
        end
      endcase
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int unsigned      ADDR_W      = 4,
  parameter int unsigned      DATA_W      = 32,
  parameter int unsigned      CNT_W       = 24,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] CAL_TENMS   = '0,
  parameter bit               CAL_SKEW    = 1'b0,
  parameter bit               CAL_NOREF   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wr_data,
  input  logic              bus_rd_en,
  output logic [DATA_W-1:0] bus_rd_data,
  output logic              irq_o
);
  ctrl_t            ctrl_w;
  logic             en_w, ie_w, src_w;
  logic [CNT_W-1:0] reload_w, cnt_w;
  logic             flag_w, step_w, cvr_wr_w, csr_rd_w;

  assign en_w  = ctrl_w.en;
  assign ie_w  = ctrl_w.ie;
  assign src_w = ctrl_w.src;

  tick_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CAL_TENMS(CAL_TENMS), .CAL_SKEW(CAL_SKEW), .CAL_NOREF(CAL_NOREF)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .wr_en(bus_wr_en), .wr_data(bus_wr_data),
    .rd_en(bus_rd_en), .rd_data(bus_rd_data),
    .cnt_i(cnt_w), .flag_i(flag_w),
    .ctrl_o(ctrl_w), .reload_o(reload_w),
    .count_clr_o(cvr_wr_w), .flag_rd_o(csr_rd_w)
  );

  tick_src #(.SYNC_STAGES(SYNC_STAGES)) src_i (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_tick_i),
    .en_i(en_w), .src_clk_i(src_w), .step_o(step_w)
  );

  tick_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .step_i(step_w), .reload_i(reload_w),
    .ie_i(ie_w), .clr_i(cvr_wr_w), .rd_clr_i(csr_rd_w),
    .cnt_o(cnt_w), .flag_o(flag_w), .irq_o(irq_o)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic              bus_rd_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rd_data,
  input logic              step_w,
  input logic              en_w,
  input logic              ie_w,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [CNT_W-1:0]  reload_w,
  input logic              flag_w,
  input logic              cvr_wr_w
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(ie_w) && cnt_w == '0));

  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_w && !cvr_wr_w) |=> $stable(cnt_w));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cvr_wr_w |=> (cnt_w == '0 && !flag_w));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && cnt_w == ONE && !cvr_wr_w) |=> flag_w);

  p_zero_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_w == '0 && cnt_w == '0 && !cvr_wr_w) |=> (cnt_w == '0 && !irq_o));

  p_fresh_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && cnt_w == '0 && !cvr_wr_w) |=> (cnt_w == $past(reload_w) && !irq_o));

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && (bus_addr[3:2] == 2'd1 || bus_addr[3:2] == 2'd2))
      |-> (bus_rd_data[DATA_W-1:CNT_W] == '0));
endmodule

bind tick_timer tick_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .bus_rd_en(bus_rd_en),
  .bus_addr(bus_addr), .bus_rd_data(bus_rd_data), .step_w(step_w),
  .en_w(en_w), .ie_w(ie_w), .cnt_w(cnt_w), .reload_w(reload_w),
  .flag_w(flag_w), .cvr_wr_w(cvr_wr_w)
);

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/1ps
module tick_timer_tb_top;
  localparam logic [31:0] CAL_WORD = 32'h4000_2710;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_tick_i;
  logic [3:0]  bus_addr;
  logic        bus_wr_en;
  logic [31:0] bus_wr_data;
  logic        bus_rd_en;
  logic [31:0] bus_rd_data;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int irq_count = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tick_timer #(.CAL_TENMS(24'd10000), .CAL_SKEW(1'b1), .CAL_NOREF(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick_i), .bus_addr(bus_addr),
    .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en),
    .bus_rd_data(bus_rd_data), .irq_o(irq_o)
  );

  // behavioural reference model
  int m_cnt, m_rel, m_s1, m_s2, m_s3;
  bit m_en, m_ie, m_src, m_flag, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_en = 0; m_ie = 0; m_src = 1; m_flag = 0; m_irq = 0;
    end else begin
      bit step, nirq;
      int sel;
      cyc++;
      sel  = int'(bus_addr[3:2]);
      step = m_en && (m_src || (m_s2 == 1 && m_s3 == 0));
      nirq = 0;
      if (bus_wr_en && sel == 2) begin
        m_cnt = 0; m_flag = 0;
      end else begin
        if (bus_rd_en && sel == 0) m_flag = 0;
        if (step) begin
          if (m_cnt == 0) m_cnt = m_rel;
          else begin
            if (m_cnt == 1) begin m_flag = 1; nirq = m_ie; end
            m_cnt = m_cnt - 1;
          end
        end
      end
      m_irq = nirq;
      if (bus_wr_en && sel == 0) begin
        m_en = bus_wr_data[0]; m_ie = bus_wr_data[1]; m_src = bus_wr_data[2];
      end
      if (bus_wr_en && sel == 1) m_rel = int'(bus_wr_data & 32'h00FF_FFFF);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(ref_tick_i);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [31:0] exp;
      if (irq_o) irq_count++;
      chk("R7 irq vs model", {31'd0, irq_o}, {31'd0, m_irq});
      if (bus_rd_en) begin
        case (bus_addr[3:2])
          2'd0: exp = {15'd0, m_flag, 13'd0, m_src, m_ie, m_en};
          2'd1: exp = m_rel;
          2'd2: exp = m_cnt;
          default: exp = CAL_WORD;
        endcase
        chk("R6 readback vs model", bus_rd_data, exp);
      end
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
    @(posedge clk); #1;
    bus_wr_en = 1'b0; bus_wr_data = '0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    d = bus_rd_data;
    @(posedge clk); #1;
    bus_rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic wait_irq(output int at);
    at = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (irq_o) begin at = cyc; break; end
    end
    if (at < 0) chk("R7 irq never seen", 32'd0, 32'd1);
  endtask

  task automatic ref_pulses(input int n, input int hi);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; ref_tick_i = 1'b1;
      repeat (hi) @(posedge clk);
      #1; ref_tick_i = 1'b0;
      repeat (4) @(posedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog: run not complete, actual %0d cycles expected under 100000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v1, v2;
    int t1, t2, base;
    rst_n = 1'b0; ref_tick_i = 1'b0; bus_addr = '0;
    bus_wr_en = 1'b0; bus_wr_data = '0; bus_rd_en = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state, R12 calibration contents
    rd_chk("R1 control reset", 4'h0, 32'h0000_0004);
    rd_chk("R1 reload reset", 4'h4, 32'h0);
    rd_chk("R1 count reset", 4'h8, 32'h0);
    rd_chk("R12 calibration word", 4'hC, CAL_WORD);
    bus_wr(4'hC, 32'hFFFF_FFFF);
    rd_chk("R12 calibration read-only", 4'hC, CAL_WORD);

    // R3 upper bits dropped
    bus_wr(4'h4, 32'hFFFF_FFFF);
    rd_chk("R3 reload upper bits", 4'h4, 32'h00FF_FFFF);

    // R2 only defined control bits are stored
    bus_wr(4'h0, 32'hFFFE_FFF8);
    rd_chk("R2 control undefined bits", 4'h0, 32'h0);
    bus_wr(4'h0, 32'h0000_0004);

    // R8 count write clears regardless of data, R11 fresh load
    bus_wr(4'h4, 32'd4);
    bus_wr(4'h8, 32'hDEAD_BEEF);
    rd_chk("R8 count cleared", 4'h8, 32'h0);
    base = irq_count;
    bus_wr(4'h0, 32'h7);
    rd_chk("R11 first step loads reload", 4'h8, 32'd4);
    chk("R11 no irq on load", irq_count, base);

    // R6 flag set on wrap, read returns and clears
    wait_irq(t1);
    rd_chk("R6 flag seen", 4'h0, 32'h0001_0007);
    rd_chk("R6 flag cleared by read", 4'h0, 32'h0000_0007);

    // R5 period of reload+1 steps
    bus_wr(4'h4, 32'd9);
    wait_irq(t1);
    wait_irq(t2);
    chk("R5 period", t2 - t1, 32'd10);

    // R7 interrupt gated by bit 1, flag still sets
    bus_wr(4'h0, 32'h5);
    base = irq_count;
    repeat (30) @(posedge clk);
    chk("R7 no irq when masked", irq_count, base);
    rd_chk("R7 flag still sets", 4'h0, 32'h0001_0005);

    // R4 disabled holds
    bus_wr(4'h0, 32'h6);
    bus_rd(4'h8, v1);
    repeat (10) @(posedge clk);
    bus_rd(4'h8, v2);
    chk("R4 count holds when disabled", v2, v1);

    // R4 clock source counts each clock
    bus_wr(4'h4, 32'd200);
    bus_wr(4'h8, 32'd0);
    bus_wr(4'h0, 32'h5);
    bus_rd(4'h8, v1);
    bus_rd(4'h8, v2);
    chk("R4 one step per clock", v1 - v2, 32'd2);

    // R10 zero reload stays at zero
    bus_wr(4'h0, 32'h4);
    bus_wr(4'h4, 32'd0);
    bus_wr(4'h8, 32'd0);
    base = irq_count;
    bus_wr(4'h0, 32'h7);
    repeat (20) @(posedge clk);
    rd_chk("R10 count stays zero", 4'h8, 32'h0);
    chk("R10 no irq", irq_count, base);

    // R9 external reference, one step per rising edge
    bus_wr(4'h0, 32'h3);
    bus_wr(4'h4, 32'd2);
    bus_wr(4'h8, 32'd0);
    base = irq_count;
    ref_pulses(3, 4);
    repeat (6) @(posedge clk);
    chk("R9 three edges one wrap", irq_count - base, 32'd1);
    ref_pulses(3, 12);
    repeat (6) @(posedge clk);
    chk("R9 long highs count once", irq_count - base, 32'd2);
    rd_chk("R9 count after wrap", 4'h8, 32'h0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule